// File: doc/BRIEF.md
# Wait-State External Memory Write Controller

This block runs single write cycles from an on-chip bus master out to external memory or to memory-mapped peripherals. A write request carries an address, a data word, a bank number and a flag that asks for a DMA grant pulse. The request arrives on a valid/ready handshake. The controller first puts the address on the bus and drives the selected bank's active-low chip select. It then pulls the active-low write strobe down and drives the data bus while the strobe is low. After the strobe it can add an address-hold cycle, a bus-release cycle, or both, before it takes the next request.

The length of the strobe depends on the wait-state configuration. A 3-bit count sets the number of programmed wait states. A 2-bit mode decides how that count combines with the external acknowledge input: the count alone, the acknowledge alone, whichever finishes first, or both of them. All configuration inputs are captured when a request is accepted, so changing them mid-access has no effect on that access.

Back-pressure rule: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its payload stable until that edge. `req_ready` stays low until the last optional phase of the access has completed.

Top module: `ext_wr_ctrl`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is taken on a clock edge with `req_valid` and `req_ready` both high. `busy` then stays high until the access, including any hold and release cycles, has finished.
- R2: The first cycle after acceptance is a setup cycle. In it, `mem_addr` carries the request address, only the selected bank's `mem_sel_n` bit is low (bit index = `req_bank`), `mem_wr_n` is high and `mem_data_oe` is low.
- R3: With mode 00 (count only), the strobe lasts `cfg_wait_cnt`+1 cycles and `mem_ack` is ignored.
- R4: With mode 01 (acknowledge only), `mem_ack` is sampled on every strobe cycle, including the first. The strobe ends after the first cycle in which it is high.
- R5: With mode 10 (either), the strobe ends when the count has run out or when `mem_ack` is high, whichever comes first. Its length is min(`cfg_wait_cnt`+1, first acknowledged cycle).
- R6: With mode 11 (both), acknowledge only counts once the wait count has run out. The strobe length is max(`cfg_wait_cnt`+1, first acknowledged cycle). With a count of 0, acknowledge applies from the first strobe cycle.
- R7: `mem_data_oe` is high exactly while `mem_wr_n` is low. During that time `mem_data_out` equals the request data and stays stable.
- R8: With `cfg_hold_en` set, exactly one cycle follows the strobe in which the address and the bank select stay valid, `mem_wr_n` is high and `mem_data_oe` is low.
- R9: With `cfg_idle_en` set, exactly one release cycle follows the strobe (or the hold cycle, if there is one). In it all selects are high, `mem_data_oe` is low and `busy` is still high.
- R10: When the request's DMA flag is set, `dma_grant_n` goes low for exactly one cycle: the first cycle after the strobe has returned high. Without the flag it stays high.
- R11: After reset: `mem_wr_n` = 1, all `mem_sel_n` bits = 1, `mem_data_oe` = 0, `dma_grant_n` = 1, `busy` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_bank | input | BANK_W | Bank number to select |
| req_dma | input | 1 | Request a DMA grant pulse after the strobe |
| cfg_wait_cnt | input | WCNT_W | Programmed wait states |
| cfg_wait_mode | input | 2 | 00 count, 01 acknowledge, 10 either, 11 both |
| cfg_hold_en | input | 1 | Add one address-hold cycle |
| cfg_idle_en | input | 1 | Add one bus-release cycle |
| mem_ack | input | 1 | External acknowledge |
| mem_addr | output | ADDR_W | External address |
| mem_sel_n | output | NBANK | Active-low bank selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_data_out | output | DATA_W | Write data to the bus |
| mem_data_oe | output | 1 | Data-bus output enable |
| dma_grant_n | output | 1 | Active-low DMA grant pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench targets the edges of the strobe-length rules. It drives acknowledge on the very first strobe cycle, which a design that skips that sample would stretch. It holds acknowledge high throughout in count-only mode, where a design that wrongly reads it would cut the strobe short. It uses Either and Both mode with acknowledge both earlier and later than the count, which separates min from max; a design that swapped the two modes, or that started counting from 1, would be off by a cycle. It also keeps `req_valid` high across a whole access to confirm that a second request is not taken early. Finally, it checks that the grant pulse, hold cycle and release cycle each occupy exactly their own cycle, in that order.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_REL    = 3'd4
  } ewc_state_t;

  typedef enum logic [1:0] {
    WM_COUNT = 2'b00,
    WM_ACK   = 2'b01,
    WM_ANY   = 2'b10,
    WM_ALL   = 2'b11
  } ewc_wmode_t;
endpackage

// File: rtl/ewc_req_latch.sv
module ewc_req_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BANK_W = 2,
  parameter int WCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BANK_W-1:0] in_bank,
  input  logic              in_dma,
  input  logic [WCNT_W-1:0] in_wcnt,
  input  logic [1:0]        in_mode,
  input  logic              in_hold,
  input  logic              in_idle,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data,
  output logic [BANK_W-1:0] q_bank,
  output logic              q_dma,
  output logic [WCNT_W-1:0] q_wcnt,
  output ewc_pkg::ewc_wmode_t q_mode,
  output logic              q_hold,
  output logic              q_idle
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr <= '0;
      q_data <= '0;
      q_bank <= '0;
      q_dma  <= 1'b0;
      q_wcnt <= '0;
      q_mode <= ewc_pkg::WM_COUNT;
      q_hold <= 1'b0;
      q_idle <= 1'b0;
    end else if (take) begin
      q_addr <= in_addr;
      q_data <= in_data;
      q_bank <= in_bank;
      q_dma  <= in_dma;
      q_wcnt <= in_wcnt;
      q_mode <= ewc_pkg::ewc_wmode_t'(in_mode);
      q_hold <= in_hold;
      q_idle <= in_idle;
    end
  end
endmodule

// File: rtl/ewc_wait_timer.sv
module ewc_wait_timer #(
  parameter int WCNT_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WCNT_W-1:0]   load_val,
  input  logic                run,
  input  ewc_pkg::ewc_wmode_t mode,
  input  logic                ack,
  output logic                done
);
  logic [WCNT_W-1:0] cnt;
  logic              expired;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && !expired) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      ewc_pkg::WM_COUNT: done = expired;
      ewc_pkg::WM_ACK:   done = ack;
      ewc_pkg::WM_ANY:   done = expired || ack;
      ewc_pkg::WM_ALL:   done = expired && ack;
      default:           done = expired;
    endcase
  end
endmodule

// File: rtl/ewc_seq.sv
module ewc_seq (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                strobe_done,
  input  logic                hold_en,
  input  logic                idle_en,
  input  logic                dma_flag,
  output ewc_pkg::ewc_state_t state,
  output logic                dma_pulse
);
  import ewc_pkg::*;
  ewc_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (take) nxt = ST_SETUP;
      ST_SETUP:  nxt = ST_STROBE;
      ST_STROBE: if (strobe_done) nxt = hold_en ? ST_HOLD : (idle_en ? ST_REL : ST_IDLE);
      ST_HOLD:   nxt = idle_en ? ST_REL : ST_IDLE;
      ST_REL:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dma_pulse <= 1'b0;
    end else begin
      state     <= nxt;
      dma_pulse <= (state == ST_STROBE) && strobe_done && dma_flag;
    end
  end
endmodule

// File: rtl/ext_wr_ctrl.sv
module ext_wr_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NBANK  = 4,
  parameter int WCNT_W = 3,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_dma,
  input  logic [WCNT_W-1:0] cfg_wait_cnt,
  input  logic [1:0]        cfg_wait_mode,
  input  logic              cfg_hold_en,
  input  logic              cfg_idle_en,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NBANK-1:0]  mem_sel_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] mem_data_out,
  output logic              mem_data_oe,
  output logic              dma_grant_n,
  output logic              busy
);
  import ewc_pkg::*;

  ewc_state_t        state;
  ewc_wmode_t        lat_mode;
  logic              take;
  logic              strobe_done;
  logic              dma_pulse;
  logic              sel_active;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [BANK_W-1:0] lat_bank;
  logic              lat_dma;
  logic [WCNT_W-1:0] lat_wcnt;
  logic              lat_hold;
  logic              lat_idle;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign take      = req_valid && req_ready;

  ewc_req_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .WCNT_W(WCNT_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .take(take),
    .in_addr(req_addr), .in_data(req_data), .in_bank(req_bank), .in_dma(req_dma),
    .in_wcnt(cfg_wait_cnt), .in_mode(cfg_wait_mode),
    .in_hold(cfg_hold_en), .in_idle(cfg_idle_en),
    .q_addr(lat_addr), .q_data(lat_data), .q_bank(lat_bank), .q_dma(lat_dma),
    .q_wcnt(lat_wcnt), .q_mode(lat_mode), .q_hold(lat_hold), .q_idle(lat_idle)
  );

  ewc_wait_timer #(.WCNT_W(WCNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(state == ST_SETUP), .load_val(lat_wcnt),
    .run(state == ST_STROBE), .mode(lat_mode), .ack(mem_ack),
    .done(strobe_done)
  );

  ewc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .strobe_done(strobe_done),
    .hold_en(lat_hold), .idle_en(lat_idle), .dma_flag(lat_dma),
    .state(state), .dma_pulse(dma_pulse)
  );

  assign sel_active   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign mem_addr     = lat_addr;
  assign mem_wr_n     = (state != ST_STROBE);
  assign mem_data_oe  = (state == ST_STROBE);
  assign mem_data_out = mem_data_oe ? lat_data : '0;
  assign dma_grant_n  = !dma_pulse;

  for (genvar b = 0; b < NBANK; b++) begin : g_sel
    assign mem_sel_n[b] = !(sel_active && (lat_bank == BANK_W'(b)));
  end
endmodule

// File: rtl/ewc_checker.sv
module ewc_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NBANK  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NBANK-1:0]  mem_sel_n,
  input logic              mem_wr_n,
  input logic [DATA_W-1:0] mem_data_out,
  input logic              mem_data_oe,
  input logic              dma_grant_n
);
  p_take_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  p_setup_before_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> (!(&mem_sel_n) && $stable(mem_sel_n) && $stable(mem_addr)));

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_sel_n) <= 1);

  p_oe_in_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_data_oe |-> !mem_wr_n);

  p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_data_out) && $stable(mem_addr)));

  p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_wr_n) && !(&mem_sel_n)) |-> $stable(mem_addr));

  p_release_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (&mem_sel_n)) |-> (!mem_data_oe && mem_wr_n));

  p_grant_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_grant_n |-> (mem_wr_n && !$past(mem_wr_n)));
endmodule

bind ext_wr_ctrl ewc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK)
) u_ewc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
  .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe), .dma_grant_n(dma_grant_n)
);

// File: tb/ext_wr_ctrl_tb_top.sv
module ext_wr_ctrl_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int NBANK  = 4;
  localparam int WCNT_W = 3;
  localparam int BANK_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [BANK_W-1:0] req_bank = '0;
  logic              req_dma = 1'b0;
  logic [WCNT_W-1:0] cfg_wait_cnt = '0;
  logic [1:0]        cfg_wait_mode = 2'b00;
  logic              cfg_hold_en = 1'b0;
  logic              cfg_idle_en = 1'b0;
  logic              mem_ack = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [NBANK-1:0]  mem_sel_n;
  logic              mem_wr_n;
  logic [DATA_W-1:0] mem_data_out;
  logic              mem_data_oe;
  logic              dma_grant_n;
  logic              busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ext_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK), .WCNT_W(WCNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_bank(req_bank), .req_dma(req_dma),
    .cfg_wait_cnt(cfg_wait_cnt), .cfg_wait_mode(cfg_wait_mode),
    .cfg_hold_en(cfg_hold_en), .cfg_idle_en(cfg_idle_en), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
    .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe),
    .dma_grant_n(dma_grant_n), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One access: mode, wait count, hold, idle, ack cycle (0 = never), force ack high, dma flag
  task automatic run_access(input logic [1:0] mode, input int w, input bit hold, input bit idle,
                            input int ack_at, input bit ack_force, input bit dma,
                            input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input int bank, input int exp_strobe, input string req);
    int n_setup = 0, n_strobe = 0, n_hold = 0, n_rel = 0;
    int dma_cnt = 0, dma_idx = -1, last_strobe = -1;
    bit data_ok = 1'b1, sel_ok = 1'b1, addr_ok = 1'b1, order_ok = 1'b1;
    logic [NBANK-1:0] exp_sel;
    exp_sel = ~(NBANK'(1) << bank);
    cfg_wait_mode = mode; cfg_wait_cnt = WCNT_W'(w);
    cfg_hold_en = hold; cfg_idle_en = idle;
    req_addr = a; req_data = d; req_bank = BANK_W'(bank); req_dma = dma;
    req_valid = 1'b1;
    mem_ack = ack_force;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      chk(req_ready == !busy, "R1", "ready vs busy", req_ready, !busy);
      if (!mem_wr_n) begin
        n_strobe++;
        last_strobe = i;
        if (!mem_data_oe || mem_data_out != d) data_ok = 1'b0;
        if (mem_sel_n != exp_sel) sel_ok = 1'b0;
        if (mem_addr != a) addr_ok = 1'b0;
        if (n_hold > 0 || n_rel > 0) order_ok = 1'b0;
      end else begin
        if (mem_data_oe) data_ok = 1'b0;
        if (busy && !(&mem_sel_n)) begin
          if (mem_sel_n != exp_sel) sel_ok = 1'b0;
          if (mem_addr != a) addr_ok = 1'b0;
          if (n_strobe == 0) n_setup++;
          else begin n_hold++; if (n_rel > 0) order_ok = 1'b0; end
        end else if (busy) begin
          n_rel++;
        end
      end
      if (!dma_grant_n) begin dma_cnt++; dma_idx = i; end
      if (ack_force) mem_ack = 1'b1;
      else mem_ack = (!mem_wr_n && ack_at > 0 && n_strobe >= ack_at);
      if (!busy) break;
    end
    mem_ack = 1'b0;
    chk(n_setup == 1, "R2", {req, " setup cycles"}, n_setup, 1);
    chk(sel_ok && addr_ok, "R2", {req, " address/select valid"}, sel_ok, 1);
    chk(n_strobe == exp_strobe, req, "strobe length", n_strobe, exp_strobe);
    chk(data_ok, "R7", {req, " data bus during strobe"}, data_ok, 1);
    chk(n_hold == int'(hold), "R8", {req, " hold cycles"}, n_hold, int'(hold));
    chk(n_rel == int'(idle), "R9", {req, " release cycles"}, n_rel, int'(idle));
    chk(order_ok, "R9", {req, " phase order"}, order_ok, 1);
    chk(dma_cnt == int'(dma), "R10", {req, " grant pulse count"}, dma_cnt, int'(dma));
    if (dma) chk(dma_idx == last_strobe + 1, "R10", {req, " grant pulse cycle"}, dma_idx, last_strobe + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_wr_n == 1'b1, "R11", "wr_n after reset", mem_wr_n, 1);
    chk(&mem_sel_n, "R11", "selects after reset", mem_sel_n, (1 << NBANK) - 1);
    chk(!mem_data_oe && dma_grant_n, "R11", "oe/grant after reset", mem_data_oe, 0);
    chk(!busy && req_ready, "R11", "busy/ready after reset", busy, 0);
  endtask

  task automatic t_count_mode();
    run_access(2'b00, 0, 0, 0, 0, 1'b1, 0, 16'h1234, 16'hA5A5, 0, 1, "R3");
    run_access(2'b00, 3, 0, 0, 0, 1'b1, 1, 16'h2222, 16'h5A5A, 1, 4, "R3");
    run_access(2'b00, 7, 0, 0, 0, 1'b0, 0, 16'hFFFE, 16'h0F0F, 3, 8, "R3");
  endtask

  task automatic t_ack_mode();
    run_access(2'b01, 5, 0, 0, 1, 1'b0, 0, 16'h0100, 16'h1111, 2, 1, "R4");
    run_access(2'b01, 0, 0, 0, 6, 1'b0, 1, 16'h0200, 16'h2222, 0, 6, "R4");
  endtask

  task automatic t_either_mode();
    run_access(2'b10, 6, 0, 0, 2, 1'b0, 0, 16'h0300, 16'h3333, 1, 2, "R5");
    run_access(2'b10, 2, 0, 0, 0, 1'b0, 0, 16'h0301, 16'h3334, 1, 3, "R5");
  endtask

  task automatic t_both_mode();
    run_access(2'b11, 2, 0, 0, 1, 1'b0, 0, 16'h0400, 16'h4444, 3, 3, "R6");
    run_access(2'b11, 1, 0, 0, 5, 1'b0, 0, 16'h0401, 16'h4445, 2, 5, "R6");
    run_access(2'b11, 0, 0, 0, 1, 1'b0, 0, 16'h0402, 16'h4446, 0, 1, "R6");
  endtask

  task automatic t_hold_idle();
    run_access(2'b00, 1, 1, 0, 0, 1'b0, 1, 16'h0500, 16'h5555, 1, 2, "R8");
    run_access(2'b00, 0, 0, 1, 0, 1'b0, 1, 16'h0501, 16'h5556, 2, 1, "R9");
    run_access(2'b01, 0, 1, 1, 3, 1'b0, 1, 16'h0502, 16'h5557, 3, 3, "R9");
  endtask

  task automatic t_backpressure();
    int strobes_a = 0;
    bit a_ok = 1'b1, early = 1'b0;
    cfg_wait_mode = 2'b00; cfg_wait_cnt = 3'd2; cfg_hold_en = 1'b1; cfg_idle_en = 1'b1;
    req_addr = 16'h0600; req_data = 16'hAAAA; req_bank = 2'd0; req_dma = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_addr = 16'h0700; req_data = 16'hBBBB; req_bank = 2'd1;
    for (int i = 0; i < 20; i++) begin
      if (!mem_wr_n) begin
        strobes_a++;
        if (mem_data_out != 16'hAAAA) a_ok = 1'b0;
      end
      if (busy && req_ready) early = 1'b1;
      if (!busy) break;
      @(negedge clk);
    end
    chk(!early, "R1", "ready held low while busy", early, 0);
    chk(a_ok && strobes_a == 3, "R1", "first request strobe unaffected", strobes_a, 3);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && mem_sel_n == 4'b1101 && mem_addr == 16'h0700, "R1", "second request taken after idle",
        mem_sel_n, 4'b1101);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!mem_wr_n) begin
        chk(mem_data_out == 16'hBBBB, "R7", "second request data", mem_data_out, 16'hBBBB);
        break;
      end
    end
    for (int i = 0; i < 20; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    chk(!busy, "R1", "back to idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_mode();
    t_ack_mode();
    t_either_mode();
    t_both_mode();
    t_hold_idle();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule